// File: doc/BRIEF.md
# Debounced Button Increment Pulser

This block takes a single raw push-button line, which reads low while pressed, and turns it into two clean signals for a time-of-day counter that runs on the same clock: a debounced button level, and a one-clock increment pulse on each accepted press. Everything is synchronous to one clock. No derived clock and no second edge feeds any counter.

A free-running prescaler produces a one-cycle sampling strobe each time it wraps. The raw line passes through a two-flop synchronizer and is then inverted. On each strobe the pressed/released state is shifted into a history register. The debounced level is high only while every history bit reads pressed. A registered edge detector turns the rising edge of that level into the increment pulse. The pulse can drive a minute or hour counter's count enable directly.

Top module: `btn_inc_pulser`

## Requirements
- R1: While rst_ni is low, level_o and pulse_o read 0 at once, without waiting for a clock edge. After reset is released the prescaler phase starts from zero.
- R2: btn_ni is active low: 0 means pressed and 1 means released. If btn_ni stays at 1, level_o and pulse_o never assert.
- R3: The button is sampled once every 2^PRESCALE_W clocks, on the edge where the prescaler wraps. Counting clock edges from reset release as 1, 2, ..., level_o changes only after an edge whose index is a multiple of 2^PRESCALE_W.
- R4: level_o asserts only after HIST_DEPTH consecutive pressed samples. After btn_ni falls and stays low, level_o is still 0 after (HIST_DEPTH-1)*2^PRESCALE_W clocks and is 1 by (HIST_DEPTH+1)*2^PRESCALE_W+4 clocks.
- R5: A press held for fewer than HIST_DEPTH samples produces no level and no pulse.
- R6: If any sample inside the window reads released, the count starts over and no pulse results. A later press held long enough then yields exactly one pulse.
- R7: pulse_o is high for exactly one clock. That clock is the cycle after level_o goes from 0 to 1.
- R8: Holding the button past acceptance produces no further pulse. On release, level_o drops within 2^PRESCALE_W+4 clocks and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock shared with the time counters |
| rst_ni | input | 1 | Asynchronous active-low reset |
| btn_ni | input | 1 | Raw button line, low while pressed |
| level_o | output | 1 | Debounced pressed level |
| pulse_o | output | 1 | One-clock increment request |

## Verification
Two things can land in the same cycle: the sampling strobe and a change in the synchronized button value. The most telling case is a release that reaches the history on the very strobe that would otherwise complete the pressed window. The bounce scenario provokes this by holding the button for a few sampling periods, letting go for one period and pressing again. It is judged by watching pulse_o and the acceptance latency at the ports. A monitor also checks that every change of level_o falls on a strobe boundary counted from reset.

// File: rtl/btn_pkg.sv
package btn_pkg;
  localparam int unsigned DEF_PRESCALE_W = 13;
  localparam int unsigned DEF_HIST_D     = 8;
endpackage

// File: rtl/btn_prescaler.sv
module btn_prescaler #(
  parameter int unsigned W = btn_pkg::DEF_PRESCALE_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // strobe on the wrap cycle only
  assign strobe_o = &cnt_q;

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R3
endmodule

// File: rtl/btn_sync2.sv
module btn_sync2 #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/btn_history.sv
module btn_history #(
  parameter int unsigned D = btn_pkg::DEF_HIST_D
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic press_i,
  output logic level_o
);
  logic [D-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hist_q <= '0;
    else if (strobe_i) hist_q <= {hist_q[D-2:0], press_i};
  end

  assign level_o = &hist_q;

  AST_LEVEL_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(level_o) |-> $past(strobe_i)); // R3
  AST_RISE_NEEDS_PRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |-> $past(press_i)); // R4
endmodule

// File: rtl/btn_edge.sv
module btn_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic pulse_o
);
  logic lvl_d_q;
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_d_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      lvl_d_q <= level_i;
      pulse_q <= level_i & ~lvl_d_q;
    end
  end

  assign pulse_o = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R7
  AST_PULSE_WITH_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> level_i); // R7
  AST_NO_PULSE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level_i) |=> !pulse_o); // R8
endmodule

// File: rtl/btn_inc_pulser.sv
module btn_inc_pulser #(
  parameter int unsigned PRESCALE_W = btn_pkg::DEF_PRESCALE_W,
  parameter int unsigned HIST_DEPTH = btn_pkg::DEF_HIST_D
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic level_o,
  output logic pulse_o
);
  logic strobe;
  logic btn_s;
  logic press;
  logic level;

  btn_prescaler #(.W(PRESCALE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_o(strobe)
  );

  btn_sync2 #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_ni), .q_o(btn_s)
  );

  assign press = ~btn_s;

  btn_history #(.D(HIST_DEPTH)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe),
    .press_i(press), .level_o(level)
  );

  btn_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level), .pulse_o(pulse_o)
  );

  assign level_o = level;

  AST_RELEASED_NO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && btn_s) |=> !level_o); // R2
  AST_PULSE_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> ($past(level_o) && !$past(level_o, 2))); // R7
endmodule

// File: tb/sim_btn_inc_pulser.sv
module sim_btn_inc_pulser;
  localparam int unsigned PW = 4;
  localparam int unsigned D  = 8;
  localparam int unsigned P  = 1 << PW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic btn_ni = 1'b1;
  logic level, pulse;

  int n_chk = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  int cyc = 0;
  logic lv1 = 1'b0, lv2 = 1'b0, pl1 = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  btn_inc_pulser #(.PRESCALE_W(PW), .HIST_DEPTH(D)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .btn_ni(btn_ni),
    .level_o(level), .pulse_o(pulse)
  );

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // port monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (level !== lv1) chk((cyc % P) == 0, "R3 level change off strobe (cyc mod P)", cyc % P, 0);
      if (pulse) begin
        pulse_cnt++;
        chk(level && lv1 && !lv2, "R7 pulse after rise (lvl,prev,prev2)",
            {level, lv1, lv2}, 3'b110);
        chk(!pl1, "R7 pulse width", 2, 1);
      end
      lv2 <= lv1; lv1 <= level; pl1 <= pulse;
    end else begin
      lv2 <= 1'b0; lv1 <= 1'b0; pl1 <= 1'b0;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; btn_ni = 1'b1;
    wait_cyc(3);
    chk(level == 0 && pulse == 0, "R1 reset outputs", {level, pulse}, 0);
    rst_ni = 1'b1;
    wait_cyc(6 * P);
    chk(level == 0, "R2 released line keeps level low", level, 0);
    chk(pulse_cnt == 0, "R2 released line no pulse", pulse_cnt, 0);
  endtask

  task automatic t_accept();
    int base = pulse_cnt;
    btn_ni = 1'b0;
    wait_cyc((D - 1) * P);
    chk(level == 0, "R4 level not early", level, 0);
    wait_cyc(2 * P + 4);
    chk(level == 1, "R4 level asserted by bound", level, 1);
    chk(pulse_cnt - base == 1, "R7 one pulse on accept", pulse_cnt - base, 1);
    wait_cyc(5 * P);
    chk(pulse_cnt - base == 1, "R8 no pulse while held", pulse_cnt - base, 1);
    btn_ni = 1'b1;
    wait_cyc(P + 4);
    chk(level == 0, "R8 level drops on release", level, 0);
    wait_cyc(2 * P);
    chk(pulse_cnt - base == 1, "R8 no pulse on release", pulse_cnt - base, 1);
  endtask

  task automatic t_short();
    int base = pulse_cnt;
    btn_ni = 1'b0;
    wait_cyc((D - 2) * P);
    btn_ni = 1'b1;
    wait_cyc(D * P);
    chk(level == 0, "R5 short press no level", level, 0);
    chk(pulse_cnt == base, "R5 short press no pulse", pulse_cnt - base, 0);
  endtask

  task automatic t_bounce();
    int base = pulse_cnt;
    btn_ni = 1'b0; wait_cyc(5 * P);
    btn_ni = 1'b1; wait_cyc(P);
    btn_ni = 1'b0; wait_cyc(5 * P);
    chk(level == 0, "R6 bounce restarts window", level, 0);
    btn_ni = 1'b1; wait_cyc(D * P);
    chk(pulse_cnt == base, "R6 bounce no pulse", pulse_cnt - base, 0);
    // release exactly where the window would complete
    btn_ni = 1'b0; wait_cyc((D - 1) * P);
    btn_ni = 1'b1; wait_cyc(P);
    btn_ni = 1'b0; wait_cyc(P);
    chk(pulse_cnt == base, "R6 late bounce no pulse", pulse_cnt - base, 0);
    wait_cyc((D + 1) * P + 4);
    chk(pulse_cnt - base == 1, "R6 clean press after bounce", pulse_cnt - base, 1);
    chk(level == 1, "R6 level after clean press", level, 1);
  endtask

  task automatic t_reset_held();
    rst_ni = 1'b0;
    #3;
    chk(level == 0 && pulse == 0, "R1 async reset while held", {level, pulse}, 0);
    wait_cyc(2);
    rst_ni = 1'b1;
    btn_ni = 1'b1;
    wait_cyc(D * P);
    chk(level == 0, "R1 stays low after reset", level, 0);
  endtask

  initial begin
    t_reset();
    t_accept();
    t_short();
    t_bounce();
    t_reset_held();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule